// File: doc/BRIEF.md
# SPI Register Port with Two-Stage Readback

This block is the peripheral side of a serial register interface for a configurable converter-style device. The host sends 32-bit frames, most significant bit first, and each frame is framed by chip select. The block samples the serial clock, chip select and MOSI with the local system clock. It assembles each frame and, when a complete frame ends, it issues at most one 16-bit write toward the device's register file, which sits outside this block. The register space uses 5-bit addresses.

A read takes two frames. In the first frame the host writes the target address to a dedicated readback-select address, and the block keeps that address as the pending readback address. When the next frame starts, the block takes a snapshot of the pending register and shifts it out on MISO during that frame. The host usually sends a no-operation frame at the same time. The pending address stays in place until another select frame arrives, so the same register can be polled again and again. Frame checksums are not supported. The trailing byte of each frame is ignored.

Top module: `spi_regport`

## Requirements
- R1: A frame is 32 bits, received MSB first. Bits 31:24 form the command byte, with bit 31 the valid flag and bits 28:24 the address. Bits 23:8 are data. A valid 32-bit frame to an ordinary address produces a write of those data bits to that address.
- R2: Each accepted write shows as exactly one `regWrEn` pulse of one clock. The pulse comes only after a frame has been committed by the rise of chip select.
- R3: A frame commits only if chip select rises after exactly 32 capture edges. A frame of 31 or 33 bits causes no write and no change to the readback address.
- R4: A frame whose command bit 31 is 0 is ignored.
- R5: A frame to address 0x00 is a no-operation. It never produces a write.
- R6: A frame to address 0x13 loads the pending readback address from frame bits 12:8. The other data bits are ignored, and the frame produces no write strobe.
- R7: Every frame shifts out 32 bits on MISO, MSB first: 0x00 in bits 31:24, the pending register's value in bits 23:8, and 0x00 in bits 7:0. The value is captured when chip select falls. MISO changes only on the clock edge opposite to the capture edge.
- R8: After reset the pending readback address is 0, `regWrEn` is low and MISO is low.
- R9: The pending readback address holds across any number of frames until a new select frame commits.
- R10: A write to the pending register may commit in the cycle just before the next frame's snapshot, with chip select high for only one clock. The snapshot then returns the newly written value.
- R11: MISO is low while chip select is high.
- R12: Command bits 30:29 and frame bits 7:0 have no effect on the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are oversampled with it |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select; each low period is one frame |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host; low while deselected |
| regWrEn | output | 1 | One-clock write strobe toward the register file |
| regWrAddr | output | 5 | Write address |
| regWrData | output | 16 | Write data |
| regRdAddr | output | 5 | Pending readback address presented to the register file |
| regRdData | input | 16 | Combinational read data for `regRdAddr` |

## Verification
The commit of one frame and the readback snapshot of the next frame can fall one clock apart, with the write strobe still high when the snapshot is taken. If the write targets the pending register, the snapshot must not see the old value. The bench provokes this by dropping chip select again after a single clock high, both in a directed write-then-read sequence and in randomly chosen gaps. It judges the outcome purely by the MISO word of the following frame, compared with a bench model of the register contents. A select frame followed at once by a read with the same short gap exercises the same edge for the address path.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  // Per-cycle strobes from the serial front end to the datapath
  typedef struct packed {
    logic csActive;   // chip select seen low after synchronisation
    logic load;       // frame start: snapshot readback word
    logic capture;    // capture edge: shift bitIn into frame
    logic launch;     // launch edge: advance MISO
    logic commit;     // frame end with exact bit count
    logic bitIn;      // synchronised MOSI value
  } ctlStrobes_t;

endpackage

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
  import spi_regport_pkg::*;
#(
  parameter int FRAME_W         = 32,
  parameter int SYNC_STAGES     = 2,
  parameter bit CAPTURE_ON_RISE = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        csN,
  input  logic        mosi,
  output ctlStrobes_t strb
);

  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] sclkQ, csQ, mosiQ;
  logic                   sclkD, csD;
  logic [CNT_W-1:0]       bitCnt;
  logic                   sclkS, csS, sclkRise, sclkFall, capEdge, lchEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= '0;
      csQ   <= '1;
      mosiQ <= '0;
      sclkD <= 1'b0;
      csD   <= 1'b1;
    end else begin
      sclkQ <= {sclkQ[SYNC_STAGES-2:0], sclk};
      csQ   <= {csQ[SYNC_STAGES-2:0], csN};
      mosiQ <= {mosiQ[SYNC_STAGES-2:0], mosi};
      sclkD <= sclkS;
      csD   <= csS;
    end
  end

  assign sclkS    = sclkQ[SYNC_STAGES-1];
  assign csS      = csQ[SYNC_STAGES-1];
  assign sclkRise = sclkS & ~sclkD;
  assign sclkFall = ~sclkS & sclkD;

  generate
    if (CAPTURE_ON_RISE) begin : g_capRise
      assign capEdge = sclkRise;
      assign lchEdge = sclkFall;
    end else begin : g_capFall
      assign capEdge = sclkFall;
      assign lchEdge = sclkRise;
    end
  endgenerate

  always_comb begin
    strb.csActive = ~csS;
    strb.load     = csD & ~csS;
    strb.capture  = ~csS & capEdge;
    // launch edges before the first capture would drop the leading bit
    strb.launch   = ~csS & lchEdge & (bitCnt != '0);
    strb.commit   = ~csD & csS & (bitCnt == CNT_FULL);
    strb.bitIn    = mosiQ[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strb.load) begin
      bitCnt <= '0;
    end else if (strb.capture && bitCnt != CNT_OVER) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_regport_dp.sv
module spi_regport_dp
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8,
  parameter int TAIL_W = 8,
  parameter logic [ADDR_W-1:0] NOP_ADDR = '0,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 5'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  output logic              miso,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdAddr,
  input  logic [DATA_W-1:0] regRdData
);

  localparam int FRAME_W  = CMD_W + DATA_W + TAIL_W;
  localparam int ADDR_LSB = DATA_W + TAIL_W;

  logic [FRAME_W-1:0] shiftIn, shiftOut;
  logic [ADDR_W-1:0]  pendingAddr, frmAddr;
  logic [DATA_W-1:0]  frmData, rdWord;
  logic               frmCmdOk, unusedBits;

  assign frmCmdOk = shiftIn[FRAME_W-1];
  assign frmAddr  = shiftIn[ADDR_LSB +: ADDR_W];
  assign frmData  = shiftIn[TAIL_W +: DATA_W];
  assign unusedBits = ^{shiftIn[FRAME_W-2:ADDR_LSB+ADDR_W], shiftIn[TAIL_W-1:0],
                        frmData[DATA_W-1:ADDR_W]};

  // Forward a write that lands on the pending register in the snapshot cycle
  assign rdWord = (regWrEn && regWrAddr == pendingAddr) ? regWrData : regRdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftIn  <= '0;
      shiftOut <= '0;
    end else begin
      if (strb.capture) shiftIn <= {shiftIn[FRAME_W-2:0], strb.bitIn};
      if (strb.load)
        shiftOut <= {{CMD_W{1'b0}}, rdWord, {TAIL_W{1'b0}}};
      else if (strb.launch)
        shiftOut <= {shiftOut[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingAddr <= '0;
      regWrEn     <= 1'b0;
      regWrAddr   <= '0;
      regWrData   <= '0;
    end else begin
      regWrEn <= 1'b0;
      if (strb.commit && frmCmdOk) begin
        if (frmAddr == SEL_ADDR) begin
          pendingAddr <= frmData[ADDR_W-1:0];
        end else if (frmAddr != NOP_ADDR) begin
          regWrEn   <= 1'b1;
          regWrAddr <= frmAddr;
          regWrData <= frmData;
        end
      end
    end
  end

  assign regRdAddr = pendingAddr;
  assign miso      = strb.csActive & shiftOut[FRAME_W-1];

endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W          = 5,
  parameter int DATA_W          = 16,
  parameter int CMD_W           = 8,
  parameter int TAIL_W          = 8,
  parameter int SYNC_STAGES     = 2,
  parameter bit CAPTURE_ON_RISE = 1'b1,
  parameter logic [ADDR_W-1:0] NOP_ADDR = '0,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 5'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdAddr,
  input  logic [DATA_W-1:0] regRdData
);

  localparam int FRAME_W = CMD_W + DATA_W + TAIL_W;

  ctlStrobes_t strb;

  spi_regport_ctrl #(
    .FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES), .CAPTURE_ON_RISE(CAPTURE_ON_RISE)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .strb(strb)
  );

  spi_regport_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W), .TAIL_W(TAIL_W),
    .NOP_ADDR(NOP_ADDR), .SEL_ADDR(SEL_ADDR)
  ) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .miso(miso),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] NOP_ADDR = '0,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 5'h13
) (
  input logic              clk,
  input logic              rstN,
  input logic              commit,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regWrAddr,
  input logic [ADDR_W-1:0] regRdAddr
);

  // R2
  wr_after_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> $past(commit));

  // R2
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R5 and R6
  wr_addr_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regWrAddr != NOP_ADDR && regWrAddr != SEL_ADDR));

  // R9
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(regRdAddr));

endmodule

bind spi_regport spi_regport_chk #(
  .ADDR_W(ADDR_W), .NOP_ADDR(NOP_ADDR), .SEL_ADDR(SEL_ADDR)
) chkI (
  .clk(clk), .rstN(rstN), .commit(strb.commit),
  .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regRdAddr(regRdAddr)
);

// File: tb/spi_regport_test.sv
`timescale 1ns/1ps
module spi_regport_test;

  logic        clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic        miso, regWrEn;
  logic [4:0]  regWrAddr, regRdAddr;
  logic [15:0] regWrData, regRdData;

  logic [15:0] mem [32];    // register file fed by the design's write port
  logic [15:0] expMem [32]; // bench model
  logic [4:0]  pendExp;
  int vectors = 0, miscompares = 0, wrCount = 0, expWr = 0;
  logic [4:0]  lastWrAddr;
  logic [15:0] lastWrData;
  bit done = 0;

  always #4 clk = ~clk;

  spi_regport uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  function automatic logic [15:0] initVal(input int i);
    return (16'(i) * 16'h0F1D) ^ 16'h5A5A;
  endfunction

  assign regRdData = mem[regRdAddr];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) mem[i] <= initVal(i);
    end else if (regWrEn) begin
      mem[regWrAddr] <= regWrData;
      lastWrAddr <= regWrAddr;
      lastWrData <= regWrData;
      wrCount <= wrCount + 1;
    end
  end

  function automatic logic [31:0] expRx();
    return {8'h00, expMem[pendExp], 8'h00};
  endfunction

  task automatic modelApply(input logic [31:0] w, input int nbits);
    if (nbits == 32 && w[31]) begin
      if (w[28:24] == 5'h13) pendExp = w[12:8];
      else if (w[28:24] != 5'h00) begin
        expMem[w[28:24]] = w[23:8];
        expWr++;
      end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Called at a negedge; capture on sclk rise, launch on fall
  task automatic frame(input logic [31:0] w, input int nbits, input int gap, input string tag);
    logic [31:0] rx, e;
    rx = '0;
    e = expRx();
    csN = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 32) ? w[31-i] : 1'b0;
      repeat (4) @(negedge clk);
      if (i < 32) rx[31-i] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    csN = 1'b1;
    if (nbits == 31) e[0] = 1'b0;
    chk(tag, rx, e);
    modelApply(w, nbits);
    repeat (gap) @(negedge clk);
  endtask

  function automatic logic [31:0] mkFrame(input bit ok, input logic [4:0] a, input logic [15:0] d);
    return {ok, 2'($urandom), a, d, 8'($urandom)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int w0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) expMem[i] = initVal(i);
    pendExp = 5'd0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk("R8 miso", {31'd0, miso}, 32'd0);
    chk("R8 regWrEn", {31'd0, regWrEn}, 32'd0);
    chk("R8 regRdAddr", {27'd0, regRdAddr}, 32'd0);

    // R8/R7: first frame returns register 0
    frame(32'h80000000, 32, 8, "R8 R7 first readback");
    // R1/R12: write with noisy command and tail bits
    w0 = wrCount;
    frame({1'b1, 2'b11, 5'd3, 16'hBEEF, 8'hFF}, 32, 8, "R7 readback");
    chk("R2 one strobe", wrCount - w0, 1);
    chk("R1 wr addr", {27'd0, lastWrAddr}, 32'd3);
    chk("R12 wr data", {16'd0, lastWrData}, 32'hBEEF);
    // R6: select with extra data bits set
    w0 = wrCount;
    frame({8'h93, 16'hFFE3, 8'h00}, 32, 8, "R7 readback");
    chk("R6 no strobe", wrCount - w0, 0);
    chk("R6 pending addr", {27'd0, regRdAddr}, 32'd3);
    frame(32'h80000000, 32, 8, "R6 R7 selected data");
    frame(32'h80000000, 32, 8, "R9 repeat poll");
    // R11: idle MISO
    chk("R11 idle miso", {31'd0, miso}, 32'd0);
    // R4: command flag clear
    w0 = wrCount;
    frame({8'h03, 16'h1111, 8'h00}, 32, 8, "R4 readback");
    chk("R4 no strobe", wrCount - w0, 0);
    // R3: short and long frames
    frame({8'h83, 16'h2222, 8'h00}, 31, 8, "R3 short frame");
    frame({8'h83, 16'h3333, 8'h00}, 33, 8, "R3 long frame");
    chk("R3 no strobe", wrCount - w0, 0);
    frame(32'h80000000, 32, 8, "R3 R4 unchanged");
    // R5: write to NOP address
    frame({8'h80, 16'h4444, 8'h00}, 32, 8, "R5 readback");
    chk("R5 no strobe", wrCount - w0, 0);
    // R10: write to pending register then snapshot one clock later
    frame({8'h93, 16'h0007, 8'h00}, 32, 1, "R10 select");
    frame({8'h87, 16'hC0DE, 8'h00}, 32, 1, "R10 write");
    frame(32'h80000000, 32, 8, "R10 bypass readback");

    // Random mix
    for (int k = 0; k < 60; k++) begin
      int kind, nb, gp;
      logic [31:0] w;
      kind = int'($urandom % 8);
      gp = ($urandom % 2) ? 1 : 8;
      nb = 32;
      case (kind)
        4: w = mkFrame(1'b1, 5'h13, 16'($urandom));
        5: w = mkFrame(1'b1, 5'h00, 16'($urandom));
        6: w = mkFrame(1'b0, 5'($urandom), 16'($urandom));
        7: begin w = mkFrame(1'b1, 5'($urandom), 16'($urandom)); nb = ($urandom % 2) ? 31 : 33; end
        default: w = mkFrame(1'b1, 5'($urandom), 16'($urandom));
      endcase
      frame(w, nb, gp, "R7 R10 random readback");
      chk("R11 idle miso", {31'd0, miso}, 32'd0);
    end
    repeat (20) @(negedge clk);
    chk("R2 write count", wrCount, expWr);
    for (int i = 0; i < 32; i++) chk("R1 final contents", {16'd0, mem[i]}, {16'd0, expMem[i]});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule